// File: doc/BRIEF.md
# Serial Command Front-End Decoder

This block sits at the input of a serial slave and turns the first two bytes of each chip-select window into a decoded command. Chip-select is active low. While it is low, one bit is taken from the serial data line, MSB first, on every rising edge of the serial clock. The serial lines are sampled by the block's own system clock, and edges are found by comparing each sample with the one before.

The first byte must identify this device. Its top nibble carries a fixed type code. The next two bits must be zero. The two lowest bits must equal a pair of address straps, so that up to four devices can share one bus.

When the identification byte matches, the second byte is split into three fields: an instruction nibble, a channel pointer and a register pointer. A one-cycle valid strobe then presents them. An identification byte that does not match turns the block deaf until chip-select goes high again. Any further bytes in the same window are also left to downstream logic and never raise the strobe.

Top module: `serial_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid` is 0 and `cmd_instr`, `cmd_chan` and `cmd_reg` are all 0.
- R2: A bit is captured only on a rising `sclk` edge that is seen while `csn` is low. Bytes are assembled MSB first. `sclk` activity while `csn` is high captures nothing.
- R3: The identification byte is accepted only if bits [7:4] equal 4'b0101.
- R4: The identification byte is accepted only if bits [3:2] are 2'b00.
- R5: The identification byte is accepted only if bits [1:0] equal `addr_strap` (bit 1 = A1, bit 0 = A0).
- R6: After an accepted identification byte, the eighth bit of the next byte is captured in some cycle. In the cycle after that one, `cmd_valid` is 1 for exactly one cycle. At the same time `cmd_instr` = byte[7:4], `cmd_chan` = byte[3:2] and `cmd_reg` = byte[1:0].
- R7: After a rejected identification byte, no strobe occurs until `csn` has gone high, whatever bytes follow.
- R8: `csn` high at any point clears the bit count and the command state. The next low window starts afresh with an identification byte. A partial byte is discarded.
- R9: Once the instruction byte has been decoded, further bytes in the same window produce no strobe.
- R10: `cmd_instr`, `cmd_chan` and `cmd_reg` change only in a cycle where `cmd_valid` is 1. Between strobes they hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock; data is captured on its rising edge |
| sdi | input | 1 | Serial data input, MSB first |
| addr_strap | input | 2 | Device address straps {A1, A0} |
| cmd_valid | output | 1 | One-cycle strobe for a decoded command |
| cmd_instr | output | 4 | Instruction code from the second byte |
| cmd_chan | output | 2 | Channel pointer from the second byte |
| cmd_reg | output | 2 | Register pointer from the second byte |

## Verification
The bench sends identification bytes that each break exactly one rule: the type nibble, the zero pair, or the strap address. A decoder that checked only part of the byte would strobe on one of them.

It also raises chip-select in the middle of a byte and then sends a clean command. A design that kept the stale bit count would misalign that command and decode the wrong fields.

It appends extra bytes after a valid instruction byte, and it toggles the serial clock while chip-select is high. A design with no terminal state would strobe a second time. A design that sampled while deselected would corrupt the next command.

A behavioural model is compared with the outputs on every cycle. This catches a strobe that arrives one cycle early or late, and it catches fields that drift between strobes.

// File: rtl/scd_pkg.sv
package scd_pkg;
    typedef enum logic [1:0] {
        ST_ID     = 2'd0,
        ST_INSTR  = 2'd1,
        ST_IGNORE = 2'd2,
        ST_DONE   = 2'd3
    } scd_state_e;
endpackage

// File: rtl/scd_shifter.sv
module scd_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn,
    input  logic              sclk,
    input  logic              sdi,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-2:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              sclk_prev;
    } shf_t;

    shf_t r_d, r_q;
    logic rise;

    always_comb begin
        r_d           = r_q;
        r_d.sclk_prev = sclk;
        rise          = sclk && !r_q.sclk_prev && !csn;
        byte_done     = rise && (r_q.cnt == LAST);
        byte_val      = {r_q.sh, sdi};
        if (csn) begin
            r_d.cnt = '0;
        end else if (rise) begin
            r_d.sh  = byte_val[BYTE_W-2:0];
            r_d.cnt = byte_done ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/scd_id_match.sv
module scd_id_match #(
    parameter int          BYTE_W    = 8,
    parameter int          TYPE_W    = 4,
    parameter int          ADDR_W    = 2,
    parameter logic [3:0]  TYPE_CODE = 4'b0101
) (
    input  logic [BYTE_W-1:0] id_byte,
    input  logic [ADDR_W-1:0] strap,
    output logic              id_ok
);
    localparam int ZERO_W = BYTE_W - TYPE_W - ADDR_W;

    logic type_ok, zero_ok, addr_ok;

    always_comb begin
        type_ok = id_byte[BYTE_W-1 -: TYPE_W] == TYPE_CODE[TYPE_W-1:0];
        zero_ok = id_byte[ADDR_W +: ZERO_W] == '0;
        addr_ok = id_byte[ADDR_W-1:0] == strap;
        id_ok   = type_ok && zero_ok && addr_ok;
    end
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder #(
    parameter int         BYTE_W    = 8,
    parameter int         TYPE_W    = 4,
    parameter int         ADDR_W    = 2,
    parameter int         INSTR_W   = 4,
    parameter int         PTR_W     = 2,
    parameter logic [3:0] TYPE_CODE = 4'b0101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csn,
    input  logic               sclk,
    input  logic               sdi,
    input  logic [ADDR_W-1:0]  addr_strap,
    output logic               cmd_valid,
    output logic [INSTR_W-1:0] cmd_instr,
    output logic [PTR_W-1:0]   cmd_chan,
    output logic [PTR_W-1:0]   cmd_reg
);
    import scd_pkg::*;

    typedef struct packed {
        scd_state_e         st;
        logic               valid;
        logic [INSTR_W-1:0] instr;
        logic [PTR_W-1:0]   chan;
        logic [PTR_W-1:0]   rsel;
    } dec_t;

    dec_t              r_d, r_q;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              id_ok;
    scd_state_e        st_cur;

    scd_shifter #(.BYTE_W(BYTE_W)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn       (csn),
        .sclk      (sclk),
        .sdi       (sdi),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    scd_id_match #(
        .BYTE_W(BYTE_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .TYPE_CODE(TYPE_CODE)
    ) u_idm (
        .id_byte (byte_val),
        .strap   (addr_strap),
        .id_ok   (id_ok)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (csn) begin
            r_d.st = ST_ID;
        end else if (byte_done) begin
            unique case (r_q.st)
                ST_ID:    r_d.st = id_ok ? ST_INSTR : ST_IGNORE;
                ST_INSTR: begin
                    r_d.st    = ST_DONE;
                    r_d.valid = 1'b1;
                    r_d.instr = byte_val[BYTE_W-1 -: INSTR_W];
                    r_d.chan  = byte_val[2*PTR_W-1 -: PTR_W];
                    r_d.rsel  = byte_val[PTR_W-1:0];
                end
                default:  r_d.st = r_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_ID, valid: 1'b0, instr: '0, chan: '0, rsel: '0};
        else        r_q <= r_d;
    end

    assign st_cur    = r_q.st;
    assign cmd_valid = r_q.valid;
    assign cmd_instr = r_q.instr;
    assign cmd_chan  = r_q.chan;
    assign cmd_reg   = r_q.rsel;
endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
    parameter int INSTR_W = 4,
    parameter int PTR_W   = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 csn,
    input logic                 sclk,
    input logic                 cmd_valid,
    input logic [INSTR_W-1:0]   cmd_instr,
    input logic [PTR_W-1:0]     cmd_chan,
    input logic [PTR_W-1:0]     cmd_reg,
    input scd_pkg::scd_state_e  st_cur
);
    // R6: strobe lasts exactly one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2: a strobe follows a sampled rising sclk while selected
    a_r2_edge_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(sclk) && !$past(csn)));

    // R8: deselect prevents a strobe in the next cycle
    a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        csn |=> !cmd_valid);

    // R10: fields only move with the strobe
    a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> ($stable(cmd_instr) && $stable(cmd_chan) && $stable(cmd_reg)));

    // R7: rejected window stays silent
    a_r7_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cur == scd_pkg::ST_IGNORE) |=> !cmd_valid);
endmodule

bind serial_cmd_decoder scd_checker #(.INSTR_W(INSTR_W), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn       (csn),
    .sclk      (sclk),
    .cmd_valid (cmd_valid),
    .cmd_instr (cmd_instr),
    .cmd_chan  (cmd_chan),
    .cmd_reg   (cmd_reg),
    .st_cur    (st_cur)
);

// File: tb/serial_cmd_decoder_test.sv
module serial_cmd_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csn = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [1:0] addr_strap = 2'd2;
    logic       cmd_valid;
    logic [3:0] cmd_instr;
    logic [1:0] cmd_chan, cmd_reg;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    serial_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdi(sdi),
        .addr_strap(addr_strap), .cmd_valid(cmd_valid), .cmd_instr(cmd_instr),
        .cmd_chan(cmd_chan), .cmd_reg(cmd_reg)
    );

    // behavioural reference model
    bit       m_prev;
    int       m_cnt, m_phase;   // phase 0 id, 1 instr, 2 deaf
    bit [7:0] m_sh;
    bit       e_valid;
    bit [3:0] e_instr;
    bit [1:0] e_chan, e_reg;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 0; m_cnt = 0; m_phase = 0; m_sh = 0;
            e_valid = 0; e_instr = 0; e_chan = 0; e_reg = 0;
        end else begin
            bit rise;
            rise = sclk && !m_prev && !csn;
            m_prev = sclk;
            e_valid = 0;
            if (csn) begin
                m_cnt = 0; m_phase = 0;
            end else if (rise) begin
                m_sh = {m_sh[6:0], sdi};
                m_cnt++;
                if (m_cnt == 8) begin
                    m_cnt = 0;
                    if (m_phase == 0)
                        m_phase = (m_sh[7:4] == 4'b0101 && m_sh[3:2] == 2'b00 &&
                                   m_sh[1:0] == addr_strap) ? 1 : 2;
                    else if (m_phase == 1) begin
                        e_valid = 1; e_instr = m_sh[7:4];
                        e_chan = m_sh[3:2]; e_reg = m_sh[1:0];
                        m_phase = 2;
                    end
                end
            end
        end
    end

    int       strobes;
    bit [3:0] last_instr;
    bit [1:0] last_chan, last_reg;

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if ({cmd_valid, cmd_instr, cmd_chan, cmd_reg} !==
                {e_valid, e_instr, e_chan, e_reg}) begin
                errors++;
                $display("FAIL %s: model mismatch got v=%0b i=%h c=%0d r=%0d exp v=%0b i=%h c=%0d r=%0d",
                         cur_req, cmd_valid, cmd_instr, cmd_chan, cmd_reg,
                         e_valid, e_instr, e_chan, e_reg);
            end
            if (cmd_valid === 1'b1) begin
                strobes++;
                last_instr = cmd_instr; last_chan = cmd_chan; last_reg = cmd_reg;
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk); sdi = b; sclk = 1'b0;
        wait_cyc(2);
        sclk = 1'b1;
        wait_cyc(2);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input bit [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic select();
        @(negedge clk); csn = 1'b0; wait_cyc(2);
    endtask

    task automatic deselect();
        wait_cyc(3); csn = 1'b1; wait_cyc(3);
    endtask

    task automatic start(input string req);
        cur_req = req; strobes = 0;
    endtask

    initial begin
        fork
            begin
                wait_cyc(3);
                checks++;
                if ({cmd_valid, cmd_instr, cmd_chan, cmd_reg} !== 9'd0) begin
                    errors++;
                    $display("FAIL R1: reset outputs got %h expected 0",
                             {cmd_valid, cmd_instr, cmd_chan, cmd_reg});
                end
                rst_n = 1'b1;
                wait_cyc(2);

                // R6: good command, strap 2
                start("R6");
                select(); send_byte(8'b0101_00_10); send_byte(8'hA3); deselect();
                check("R6 strobes", strobes, 1);
                check("R6 instr", last_instr, 4'hA);
                check("R6 chan", last_chan, 0);
                check("R6 reg", last_reg, 3);

                // R3: wrong type code
                start("R3");
                select(); send_byte(8'b0110_00_10); send_byte(8'h5F); send_byte(8'b0101_00_10);
                send_byte(8'h11); deselect();
                check("R3 strobes", strobes, 0);

                // R4: nonzero pad bits
                start("R4");
                select(); send_byte(8'b0101_01_10); send_byte(8'h77); deselect();
                check("R4 strobes", strobes, 0);

                // R5: address mismatch
                start("R5");
                select(); send_byte(8'b0101_00_01); send_byte(8'h66); deselect();
                check("R5 strobes", strobes, 0);

                // R7: rejected then more bytes in same window
                start("R7");
                select(); send_byte(8'hFF); send_byte(8'b0101_00_10); send_byte(8'h9C);
                send_byte(8'h42); deselect();
                check("R7 strobes", strobes, 0);

                // R8: partial byte, deselect, then clean command
                start("R8");
                select(); send_bit(1); send_bit(0); send_bit(1); deselect();
                select(); send_byte(8'b0101_00_10); send_byte(8'h6D); deselect();
                check("R8 strobes", strobes, 1);
                check("R8 instr", last_instr, 4'h6);
                check("R8 chan", last_chan, 3);
                check("R8 reg", last_reg, 1);

                // R9: extra bytes after instruction
                start("R9");
                select(); send_byte(8'b0101_00_10); send_byte(8'h24);
                send_byte(8'h35); send_byte(8'h46); deselect();
                check("R9 strobes", strobes, 1);
                check("R9 instr", last_instr, 4'h2);

                // R5: different strap value accepted
                addr_strap = 2'd1;
                start("R5");
                select(); send_byte(8'b0101_00_01); send_byte(8'h5E); deselect();
                check("R5 strobes strap1", strobes, 1);
                check("R5 instr", last_instr, 4'h5);
                check("R5 chan", last_chan, 3);
                check("R5 reg", last_reg, 2);

                // R2: sclk activity while deselected captures nothing
                start("R2");
                for (int k = 0; k < 16; k++) send_bit(k[0]);
                check("R2 strobes", strobes, 0);
                // R10: fields held
                check("R10 instr hold", cmd_instr, 4'h5);
                check("R10 chan hold", cmd_chan, 3);
                check("R10 reg hold", cmd_reg, 2);
                // R2: MSB-first assembly of an asymmetric byte
                start("R2");
                select(); send_byte(8'b0101_00_01); send_byte(8'h81); deselect();
                check("R2 msb first instr", last_instr, 4'h8);
                check("R2 msb first reg", last_reg, 1);
            end
            begin
                wait_cyc(150000);
                errors++; checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule